// File: doc/BRIEF.md
# Overcurrent Threshold Capture by Counter Ramp

This block turns an analog overcurrent setting into a digital code. A fixed current source outside the block develops a voltage on a pin, and that pin is shared with the low-side gate driver. When a sample is requested, the block holds that driver off and resets an up-counter to zero. The counter drives a DAC, and a single comparator, modelled outside the block, reports when the DAC output rises above the pin voltage. The counter steps once per tick. When the comparator trip is confirmed, the count is frozen as the held threshold code.

A low setting therefore finishes quickly, and a high setting takes longer. If the counter reaches a ceiling code with no trip, the setting is too high or the pin is open. The block then records protection as disabled instead of storing a threshold. After sampling ends, the DAC input carries the held code, which becomes the run-time threshold. A second output carries twice that code, because the voltage across the switch is compared against double the sampled voltage. The held code does not decay. It changes only when a later sample completes.

Top module: `thr_capture`

## Requirements
- R1: While reset is active and after it is released:
  - `held_code` is 0.
  - `prot_off` is 1.
  - `done` is 0.
  - `drv_inhibit` is 0.
  - `dac_code` is 0.
- R2: A `sample_req` that is high at a clock edge while idle raises `drv_inhibit` after that edge. It also restarts the counter at 0, and `dac_code` shows the counter during sampling. The counter advances by exactly one on each clock where `tick` is high. A sample that needs k steps therefore lasts between k-1 and k+1 tick periods plus the confirmation latency.
- R3: `cmp_in` passes through a two-flop synchronizer. A trip counts only when the synchronized value is high on two consecutive clocks. A high pulse of one clock on `cmp_in` is ignored.
- R4: If a tick arrives while the count equals `OFF_CODE` and no trip is confirmed, sampling ends with `prot_off` = 1 and `held_code` = `OFF_CODE`. A confirmed trip at `OFF_CODE` is still a valid threshold.
- R5: `done` is high for exactly one clock when sampling ends. `held_code` and `prot_off` take their new values in that same cycle, and `drv_inhibit` falls in that same cycle.
- R6: A `sample_req` that arrives while sampling is in progress has no effect. The count is not restarted, and the result and duration match an undisturbed sample.
- R7: Between completions, `held_code` and `prot_off` stay unchanged, and `dac_code` equals `held_code` while idle.
- R8: `limit_code` always equals twice `held_code`.
- R9: A sample that ends on a trip stores the count as `held_code` and clears `prot_off`. With the bench comparator (DAC code > pin level p), that count is p+1 for p < `OFF_CODE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_req | input | 1 | Request a new threshold capture |
| cmp_in | input | 1 | Asynchronous comparator result, high when DAC output exceeds pin voltage |
| tick | input | 1 | One-clock step strobe for the counter |
| drv_inhibit | output | 1 | Holds the low-side driver off while sampling |
| dac_code | output | CODE_W | DAC input: the ramp count while sampling, the held code otherwise |
| held_code | output | CODE_W | Captured threshold code |
| limit_code | output | CODE_W+1 | Effective switch-drop threshold, twice the held code |
| done | output | 1 | One-clock pulse at the end of a sample |
| prot_off | output | 1 | Protection disabled (setting at or above ceiling, or no valid sample) |

## Verification
The pin level is swept across every value from 0 to past the ceiling. Each level is checked for:
- the captured code,
- the disable flag,
- the doubled threshold,
- a duration that scales with the setting.

The sweep separates trips below the ceiling, a trip exactly at the ceiling, and the disabled outcome. A one-clock glitch on the comparator during a disabled-range sample must not capture a code, which distinguishes the two-sample confirmation from a single-sample trip. A repeated request mid-sample and a long idle wait after completion show that the count is not restarted and that the held code is retained.

// File: rtl/thr_capture_pkg.sv
package thr_capture_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RAMP = 1'b1
    } phase_t;

    // Trip is accepted when two successive synchronized samples are high
    function automatic logic trip_seen(input logic now_v, input logic prev_v);
        return now_v & prev_v;
    endfunction

endpackage

// File: rtl/thr_cmp_sync.sv
module thr_cmp_sync (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic din,
    output logic dout
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/thr_ramp_counter.sv
module thr_ramp_counter #(
    parameter int CODE_W = 6,
    parameter int CAP    = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    output logic [CODE_W-1:0] count
);
    localparam logic [CODE_W-1:0] CAP_V = CAP[CODE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    assert_count_cap_R4: assert property (@(posedge clk) disable iff (rst)
        count <= CAP_V);

    assert_count_monotonic_R2: assert property (@(posedge clk) disable iff (rst)
        !clear |=> count >= $past(count));
endmodule

// File: rtl/thr_capture.sv
module thr_capture
    import thr_capture_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int OFF_CODE = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_req,
    input  logic              cmp_in,
    input  logic              tick,
    output logic              drv_inhibit,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] held_code,
    output logic [CODE_W:0]   limit_code,
    output logic              done,
    output logic              prot_off
);
    localparam logic [CODE_W-1:0] OFF_V = OFF_CODE[CODE_W-1:0];

    phase_t            phase;
    logic              busy;
    logic              start;
    logic              cmp_s;
    logic              cmp_p;
    logic              trip;
    logic              at_cap;
    logic              give_up;
    logic              step;
    logic [CODE_W-1:0] count;

    assign busy    = (phase == PH_RAMP);
    assign start   = !busy && sample_req;
    assign trip    = busy && trip_seen(cmp_s, cmp_p);
    assign at_cap  = (count == OFF_V);
    assign give_up = busy && !trip && tick && at_cap;
    assign step    = busy && !trip && tick && !at_cap;

    thr_cmp_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .din  (cmp_in),
        .dout (cmp_s)
    );

    always_ff @(posedge clk) begin
        if (rst || start) cmp_p <= 1'b0;
        else              cmp_p <= cmp_s;
    end

    thr_ramp_counter #(.CODE_W(CODE_W), .CAP(OFF_CODE)) u_ramp (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .step  (step),
        .count (count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            held_code <= '0;
            prot_off  <= 1'b1;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                phase <= PH_RAMP;
            end else if (trip) begin
                phase     <= PH_IDLE;
                held_code <= count;
                prot_off  <= 1'b0;
                done      <= 1'b1;
            end else if (give_up) begin
                phase     <= PH_IDLE;
                held_code <= count;
                prot_off  <= 1'b1;
                done      <= 1'b1;
            end
        end
    end

    assign drv_inhibit = busy;
    assign dac_code    = busy ? count : held_code;
    assign limit_code  = {held_code, 1'b0};

    assert_start_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_inhibit) |-> $past(sample_req));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_ends_inhibit_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !drv_inhibit && $past(drv_inhibit));

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(held_code) && $stable(prot_off));

    assert_off_code_R4: assert property (@(posedge clk) disable iff (rst)
        (done && prot_off) |-> held_code == OFF_V);

    assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> count >= $past(count));
endmodule

// File: tb/thr_capture_test.sv
module thr_capture_test;
    localparam int CODE_W = 6;
    localparam int OFF    = 48;
    localparam int TICK_P = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sample_req = 1'b0;
    logic              tick = 1'b0;
    logic              glitch = 1'b0;
    logic              cmp_in;
    logic              drv_inhibit;
    logic [CODE_W-1:0] dac_code;
    logic [CODE_W-1:0] held_code;
    logic [CODE_W:0]   limit_code;
    logic              done;
    logic              prot_off;

    int pin = 1000;
    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    int tick_cnt = 0;
    bit hung = 0;

    always #5 clk = ~clk;

    assign cmp_in = glitch | (int'(dac_code) > pin);

    thr_capture #(.CODE_W(CODE_W), .OFF_CODE(OFF)) uut (
        .clk(clk), .rst(rst), .sample_req(sample_req), .cmp_in(cmp_in),
        .tick(tick), .drv_inhibit(drv_inhibit), .dac_code(dac_code),
        .held_code(held_code), .limit_code(limit_code), .done(done),
        .prot_off(prot_off)
    );

    always @(negedge clk) begin
        cycles++;
        tick_cnt = (tick_cnt == TICK_P - 1) ? 0 : tick_cnt + 1;
        tick <= (tick_cnt == 0);
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Runs one sample at pin level p; optional glitch or repeated request at cycle mid
    task automatic run_sample(input int p, input int mid, input bit do_glitch,
                              input bit do_req, output int dur);
        pin = p;
        @(negedge clk) sample_req = 1'b1;
        @(negedge clk) sample_req = 1'b0;
        check("R2 inhibit raised", int'(drv_inhibit), 1);
        dur = 1;
        while (!done) begin
            @(negedge clk);
            dur++;
            glitch = 1'b0;
            sample_req = 1'b0;
            if (dur == mid && do_glitch) glitch = 1'b1;
            if (dur == mid && do_req) sample_req = 1'b1;
            if (dur > 2000) begin
                hung = 1;
                n_checks++;
                n_fail++;
                $display("FAIL watchdog sample hung actual=%0d expected=%0d", dur, 0);
                finish_run();
            end
        end
        check("R5 inhibit low at done", int'(drv_inhibit), 0);
    endtask

    task automatic expect_result(input string tag, input int p, input int dur);
        int exp_code;
        int exp_off;
        int k;
        exp_off  = (p >= OFF) ? 1 : 0;
        exp_code = exp_off ? OFF : p + 1;
        k        = exp_off ? OFF + 1 : p + 1;
        check({tag, " R9/R4 held_code"}, int'(held_code), exp_code);
        check({tag, " R9/R4 prot_off"}, int'(prot_off), exp_off);
        check({tag, " R8 limit_code"}, int'(limit_code), 2 * exp_code);
        check({tag, " R2 duration low"}, int'(dur >= (k - 1) * TICK_P), 1);
        check({tag, " R2 duration high"}, int'(dur <= (k + 1) * TICK_P + 6), 1);
        @(negedge clk);
        check({tag, " R5 done one clock"}, int'(done), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        finish_run();
    end

    initial begin
        int d;
        int d_ref;
        repeat (3) @(negedge clk);
        check("R1 held in reset", int'(held_code), 0);
        check("R1 prot_off in reset", int'(prot_off), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 held", int'(held_code), 0);
        check("R1 prot_off", int'(prot_off), 1);
        check("R1 done", int'(done), 0);
        check("R1 inhibit", int'(drv_inhibit), 0);
        check("R1 dac_code", int'(dac_code), 0);

        // Sweep every pin level through the ceiling and beyond
        for (int p = 0; p <= OFF + 3; p++) begin
            run_sample(p, 0, 1'b0, 1'b0, d);
            expect_result("sweep", p, d);
        end

        // R3: one-clock comparator glitch in disabled range is ignored
        run_sample(OFF + 10, 40, 1'b1, 1'b0, d);
        expect_result("R3 glitch", OFF + 10, d);

        // R9: a trip after a disabled result clears prot_off
        run_sample(10, 0, 1'b0, 1'b0, d_ref);
        expect_result("R9 recover", 10, d_ref);

        // R6: repeated request mid-sample does not restart
        run_sample(10, 40, 1'b0, 1'b1, d);
        expect_result("R6 ignored req", 10, d);
        check("R6 duration matches", int'(d <= d_ref + TICK_P), 1);

        // R7: held value retained and shown on dac_code while idle
        pin = 0;
        repeat (60) @(negedge clk);
        check("R7 held retained", int'(held_code), 11);
        check("R7 prot_off retained", int'(prot_off), 0);
        check("R7 dac_code idle", int'(dac_code), 11);
        check("R8 limit retained", int'(limit_code), 22);

        // R4: trip exactly at ceiling is valid
        run_sample(OFF - 1, 0, 1'b0, 1'b0, d);
        expect_result("R4 at ceiling", OFF - 1, d);

        finish_run();
    end
endmodule